// File: doc/BRIEF.md
# Page Table Entry Permission Checker

This block sits at the end of an address-translation walk. It receives one access request together with the leaf page table entry that the walk produced and the table level at which the walk stopped. It decides whether the access may proceed. It reports a fault cause code and forms the physical address from the entry's frame field and the page offset. It also returns the entry with its accessed and dirty status bits brought up to date, plus a strobe that tells the walker to write the entry back to memory.

Requests enter on a valid/ready channel and results leave on a second valid/ready channel. There is one register stage. A request is taken on a clock edge where `req_valid` and `req_ready` are both high, and its result is presented with `rsp_valid` from the next cycle. `req_ready` is high whenever the result register is empty or is being drained in the same cycle (`rsp_ready` high). While `rsp_valid` is high and `rsp_ready` is low, the result is held unchanged and no new request is accepted. This back-pressure reaches the request side in the same cycle, through one gate.

Virtual addresses are 48 bits and physical addresses 52 bits. Entry bit positions are fixed: present 0, writable 1, user-allowed 2, write-through 3, accessed 5, dirty 6, large-page 7, no-execute 63, and frame bits 51 down to 12.

Top module: `pte_access_check`

## Requirements
- R1: An entry whose bit 0 (present) is 0 yields cause 1 (absent) for every access kind, whatever its other bits hold.
- R2: The leaf level selects the page size. Level 4 is a 4 KiB page, and bit 7 is ignored there. Level 3 with bit 7 set is a 2 MiB page. Level 2 with bit 7 set is a 1 GiB page. Level 3 or 2 with bit 7 clear, or any other level value, yields cause 5 (bad shape).
- R3: A user access (`req_user`=1) to an entry with bit 2 clear yields cause 2 (privilege). A supervisor access to the same entry is not refused for that reason.
- R4: A write (kind 1) to an entry with bit 1 clear yields cause 3 (write-protect). Reads of such an entry are allowed.
- R5: An instruction fetch (kind 2) from an entry with bit 63 set yields cause 4 (no-execute). Reads of such an entry are allowed. Kind 0 is a read, and kind 3 is treated as a read.
- R6: When several faults apply, the reported cause follows the order absent (1), bad shape (5), privilege (2), write-protect (3), no-execute (4). Cause 0 means granted. `rsp_fault` is high exactly when the cause is nonzero.
- R7: A granted access returns the entry with bit 5 (accessed) set, and a granted write also sets bit 6 (dirty). All other bits are unchanged. A faulting access returns the entry unchanged.
- R8: `rsp_pte_we` is high only on a granted access whose returned entry differs from the input entry. It is never high on a fault.
- R9: On a grant, `rsp_paddr` keeps the low 12, 21 or 30 virtual-address bits for a 4 KiB, 2 MiB or 1 GiB page respectively. The remaining upper bits, up to bit 51, come from the same positions of the entry.
- R10: `rsp_wt` equals entry bit 3 (write-through) of the request.
- R11: A result appears the cycle after its request is accepted. While it waits with `rsp_ready` low, it stays stable and `req_ready` is low.
- R12: After reset, `rsp_valid` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this edge when high |
| req_vaddr | input | 48 | Virtual address of the access |
| req_kind | input | 2 | 0 read, 1 write, 2 fetch, 3 read |
| req_user | input | 1 | 1 = user privilege, 0 = supervisor |
| req_level | input | 3 | Table level where the walk stopped |
| req_pte | input | 64 | Leaf page table entry |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Result taken this edge when high |
| rsp_fault | output | 1 | Access refused |
| rsp_cause | output | 3 | Fault cause code |
| rsp_paddr | output | 52 | Physical address |
| rsp_wt | output | 1 | Write-through cache attribute |
| rsp_pte | output | 64 | Entry with status bits updated |
| rsp_pte_we | output | 1 | Write the returned entry back |

## Verification
The assertions take for granted that the downstream side obeys the handshake: once `rsp_valid` rises, the result only changes after a cycle with `rsp_ready` high. They also assume that reset starts every run. The stimulus meets these conditions by driving request fields only at falling edges, and by holding each request until `req_ready` is seen high. The downstream ready is randomised only after the directed cases have drained, so that stalls exercise the hold rule with a mix of entries. Every level value and access kind in the stimulus stays within its declared field width. Reserved kind 3 and out-of-range levels are fed on purpose to check that they are handled as read and as bad shape.

// File: rtl/pte_chk_pkg.sv
package pte_chk_pkg;

  // Entry bit positions; the walker and memory image share these.
  localparam int unsigned BIT_PRESENT = 0;
  localparam int unsigned BIT_WRITE   = 1;
  localparam int unsigned BIT_USER    = 2;
  localparam int unsigned BIT_WTHRU   = 3;
  localparam int unsigned BIT_ACCESS  = 5;
  localparam int unsigned BIT_DIRTY   = 6;
  localparam int unsigned BIT_LARGE   = 7;
  localparam int unsigned BIT_NOEXEC  = 63;

  // Page offset widths per size.
  localparam int unsigned OFS_BASE = 12;
  localparam int unsigned OFS_STEP = 9;
  localparam int unsigned N_SIZES  = 3;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_e;

  typedef enum logic [2:0] {
    CZ_NONE   = 3'd0,
    CZ_ABSENT = 3'd1,
    CZ_PRIV   = 3'd2,
    CZ_WPROT  = 3'd3,
    CZ_NOEXEC = 3'd4,
    CZ_SHAPE  = 3'd5
  } cause_e;

  typedef enum logic [1:0] {
    SZ_4K = 2'd0,
    SZ_2M = 2'd1,
    SZ_1G = 2'd2
  } page_size_e;

endpackage

// File: rtl/pte_perm_eval.sv
module pte_perm_eval
  import pte_chk_pkg::*;
#(
  parameter int unsigned PTE_W = 64,
  parameter int unsigned LVL_W = 3
) (
  input  logic [PTE_W-1:0] pte_i,
  input  logic [1:0]       kind_i,
  input  logic             user_i,
  input  logic [LVL_W-1:0] level_i,
  output cause_e           cause_o,
  output page_size_e       size_o
);

  logic shape_ok;
  logic is_write, is_fetch;

  assign is_write = (kind_i == ACC_WRITE);
  assign is_fetch = (kind_i == ACC_FETCH);

  // R2: leaf level decides the page size; upper levels need the large bit.
  always_comb begin
    shape_ok = 1'b0;
    size_o   = SZ_4K;
    case (level_i)
      LVL_W'(4): begin shape_ok = 1'b1;             size_o = SZ_4K; end
      LVL_W'(3): begin shape_ok = pte_i[BIT_LARGE]; size_o = SZ_2M; end
      LVL_W'(2): begin shape_ok = pte_i[BIT_LARGE]; size_o = SZ_1G; end
      default:   begin shape_ok = 1'b0;             size_o = SZ_4K; end
    endcase
  end

  // R6: fixed priority R1 > R2 > R3 > R4 > R5.
  always_comb begin
    if (!pte_i[BIT_PRESENT])                  cause_o = CZ_ABSENT;
    else if (!shape_ok)                       cause_o = CZ_SHAPE;
    else if (user_i && !pte_i[BIT_USER])      cause_o = CZ_PRIV;
    else if (is_write && !pte_i[BIT_WRITE])   cause_o = CZ_WPROT;
    else if (is_fetch && pte_i[BIT_NOEXEC])   cause_o = CZ_NOEXEC;
    else                                      cause_o = CZ_NONE;
  end

endmodule

// File: rtl/pte_addr_form.sv
module pte_addr_form
  import pte_chk_pkg::*;
#(
  parameter int unsigned VA_W  = 48,
  parameter int unsigned PA_W  = 52,
  parameter int unsigned PTE_W = 64
) (
  input  logic [VA_W-1:0]  va_i,
  input  logic [PTE_W-1:0] pte_i,
  input  page_size_e       size_i,
  output logic [PA_W-1:0]  pa_o
);

  logic [PA_W-1:0] cand [N_SIZES];

  // R9: one candidate address per supported page size.
  for (genvar g = 0; g < int'(N_SIZES); g++) begin : g_size
    localparam int unsigned OB = OFS_BASE + OFS_STEP * g;
    assign cand[g] = {pte_i[PA_W-1:OB], va_i[OB-1:0]};
  end

  always_comb begin
    case (size_i)
      SZ_2M:   pa_o = cand[1];
      SZ_1G:   pa_o = cand[2];
      default: pa_o = cand[0];
    endcase
  end

endmodule

// File: rtl/pte_status_upd.sv
module pte_status_upd
  import pte_chk_pkg::*;
#(
  parameter int unsigned PTE_W = 64
) (
  input  logic [PTE_W-1:0] pte_i,
  input  logic             grant_i,
  input  logic             write_i,
  output logic [PTE_W-1:0] pte_o,
  output logic             we_o
);

  // R7: mark accessed on any grant, dirty on a granted write.
  always_comb begin
    pte_o = pte_i;
    if (grant_i) begin
      pte_o[BIT_ACCESS] = 1'b1;
      if (write_i) pte_o[BIT_DIRTY] = 1'b1;
    end
  end

  // R8: write back only when a status bit actually flips.
  assign we_o = grant_i & (~pte_i[BIT_ACCESS] | (write_i & ~pte_i[BIT_DIRTY]));

  always_comb begin
    if (we_o) begin
      assert_strobe_changes_R8: assert (pte_o != pte_i);
    end
  end

endmodule

// File: rtl/pte_access_check.sv
module pte_access_check
  import pte_chk_pkg::*;
#(
  parameter int unsigned VA_W  = 48,
  parameter int unsigned PA_W  = 52,
  parameter int unsigned PTE_W = 64,
  parameter int unsigned LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic [1:0]       req_kind,
  input  logic             req_user,
  input  logic [LVL_W-1:0] req_level,
  input  logic [PTE_W-1:0] req_pte,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic             rsp_fault,
  output logic [2:0]       rsp_cause,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic             rsp_wt,
  output logic [PTE_W-1:0] rsp_pte,
  output logic             rsp_pte_we
);

  cause_e           cause_c;
  page_size_e       size_c;
  logic [PA_W-1:0]  pa_c;
  logic [PTE_W-1:0] pte_c;
  logic             we_c;
  logic             grant_c;
  logic             take;

  pte_perm_eval #(.PTE_W(PTE_W), .LVL_W(LVL_W)) u_perm (
    .pte_i(req_pte), .kind_i(req_kind), .user_i(req_user),
    .level_i(req_level), .cause_o(cause_c), .size_o(size_c)
  );

  pte_addr_form #(.VA_W(VA_W), .PA_W(PA_W), .PTE_W(PTE_W)) u_addr (
    .va_i(req_vaddr), .pte_i(req_pte), .size_i(size_c), .pa_o(pa_c)
  );

  assign grant_c = (cause_c == CZ_NONE);

  pte_status_upd #(.PTE_W(PTE_W)) u_stat (
    .pte_i(req_pte), .grant_i(grant_c),
    .write_i(req_kind == ACC_WRITE), .pte_o(pte_c), .we_o(we_c)
  );

  // R11: single stage, ready passes through when the slot drains.
  assign req_ready = ~rsp_valid | rsp_ready;
  assign take      = req_valid & req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;                 // R12
    end else if (req_ready) begin
      rsp_valid <= req_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_fault  <= 1'b0;
      rsp_cause  <= CZ_NONE;
      rsp_paddr  <= '0;
      rsp_wt     <= 1'b0;
      rsp_pte    <= '0;
      rsp_pte_we <= 1'b0;
    end else if (take) begin
      rsp_fault  <= ~grant_c;
      rsp_cause  <= cause_c;
      rsp_paddr  <= pa_c;
      rsp_wt     <= req_pte[BIT_WTHRU];   // R10
      rsp_pte    <= pte_c;
      rsp_pte_we <= we_c;
    end
  end

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_cause) &&
      $stable(rsp_paddr) && $stable(rsp_pte) && $stable(rsp_pte_we) &&
      $stable(rsp_wt) && $stable(rsp_fault)));

  assert_no_strobe_on_fault_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> !rsp_pte_we);

  assert_grant_marks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault) |-> (rsp_pte[BIT_ACCESS] && rsp_pte[BIT_PRESENT]));

  assert_absent_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_cause == CZ_ABSENT) |-> !rsp_pte[BIT_PRESENT]);

endmodule

// File: tb/pte_access_check_test.sv
module pte_access_check_test;

  typedef struct packed {
    logic        fault;
    logic [2:0]  cause;
    logic [51:0] pa;
    logic        wt;
    logic [63:0] pte;
    logic        we;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [47:0] req_vaddr = '0;
  logic [1:0]  req_kind = '0;
  logic        req_user = 1'b0;
  logic [2:0]  req_level = '0;
  logic [63:0] req_pte = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic        rsp_fault;
  logic [2:0]  rsp_cause;
  logic [51:0] rsp_paddr;
  logic        rsp_wt;
  logic [63:0] rsp_pte;
  logic        rsp_pte_we;

  int    n_chk = 0;
  int    n_bad = 0;
  bit    stall_mode = 1'b0;
  bit    done = 1'b0;
  exp_t  expq[$];
  string tagq[$];

  always #10 clk = ~clk;   // 50 MHz

  pte_access_check uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_kind(req_kind), .req_user(req_user),
    .req_level(req_level), .req_pte(req_pte), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_fault(rsp_fault), .rsp_cause(rsp_cause),
    .rsp_paddr(rsp_paddr), .rsp_wt(rsp_wt), .rsp_pte(rsp_pte),
    .rsp_pte_we(rsp_pte_we)
  );

  // Model written from the requirements.
  function automatic exp_t model(input logic [47:0] va, input logic [1:0] k,
                                 input logic u, input logic [2:0] lv,
                                 input logic [63:0] p);
    exp_t e;
    bit shape;
    int ob;
    logic [51:0] m;
    shape = (lv == 3'd4) || ((lv == 3'd3 || lv == 3'd2) && p[7]);
    ob = (lv == 3'd3) ? 21 : (lv == 3'd2) ? 30 : 12;
    if (!p[0])                 e.cause = 3'd1;
    else if (!shape)           e.cause = 3'd5;
    else if (u && !p[2])       e.cause = 3'd2;
    else if (k == 2'd1 && !p[1]) e.cause = 3'd3;
    else if (k == 2'd2 && p[63]) e.cause = 3'd4;
    else                       e.cause = 3'd0;
    e.fault = (e.cause != 3'd0);
    m = (52'd1 << ob) - 52'd1;
    e.pa = (p[51:0] & ~m) | ({4'd0, va} & m);
    e.wt = p[3];
    e.pte = p;
    if (!e.fault) begin
      e.pte[5] = 1'b1;
      if (k == 2'd1) e.pte[6] = 1'b1;
    end
    e.we = (e.pte != p);
    return e;
  endfunction

  task automatic send(input logic [47:0] va, input logic [1:0] k, input logic u,
                      input logic [2:0] lv, input logic [63:0] p, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_kind = k; req_user = u;
    req_level = lv; req_pte = p;
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    expq.push_back(model(va, k, u, lv, p));
    tagq.push_back(tag);
    @(posedge clk);
    #1;
    req_valid = 1'b0;
  endtask

  // Downstream ready: random only in stall mode.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      rsp_ready = stall_mode ? ($urandom_range(0, 3) != 0) : 1'b1;
    end
  end

  // Monitor / scoreboard.
  exp_t snap;
  bit   have_snap = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (have_snap) begin
        n_chk++;
        if (!rsp_valid || {rsp_fault, rsp_cause, rsp_paddr, rsp_wt, rsp_pte, rsp_pte_we} != snap) begin
          n_bad++;
          $display("FAIL R11 held result changed: got %h exp %h",
                   {rsp_fault, rsp_cause, rsp_paddr, rsp_wt, rsp_pte, rsp_pte_we}, snap);
        end
        have_snap = 1'b0;
      end
      if (rsp_valid && !rsp_ready) begin
        n_chk++;
        if (req_ready) begin
          n_bad++;
          $display("FAIL R11 req_ready high during stall: got 1 exp 0");
        end
        snap = {rsp_fault, rsp_cause, rsp_paddr, rsp_wt, rsp_pte, rsp_pte_we};
        have_snap = 1'b1;
      end
      if (rsp_valid && rsp_ready) begin
        n_chk++;
        if (expq.size() == 0) begin
          n_bad++;
          $display("FAIL R11 unexpected result: got cause %0d exp none", rsp_cause);
        end else begin
          exp_t e;
          string t;
          e = expq.pop_front();
          t = tagq.pop_front();
          if (rsp_fault != e.fault || rsp_cause != e.cause || rsp_wt != e.wt ||
              rsp_pte != e.pte || rsp_pte_we != e.we ||
              (!e.fault && rsp_paddr != e.pa)) begin
            n_bad++;
            $display("FAIL %s: got f=%b c=%0d pa=%h wt=%b pte=%h we=%b exp f=%b c=%0d pa=%h wt=%b pte=%h we=%b",
                     t, rsp_fault, rsp_cause, rsp_paddr, rsp_wt, rsp_pte, rsp_pte_we,
                     e.fault, e.cause, e.pa, e.wt, e.pte, e.we);
          end
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout exp completion");
    finish_run();
  end

  localparam logic [63:0] FR  = 64'h000A_BCDE_F123_4000;
  localparam logic [63:0] OK  = FR | 64'h7;
  localparam logic [47:0] VA  = 48'h7123_4567_89AB;

  initial begin
    logic [31:0] lf;
    repeat (3) @(posedge clk);
    #1;
    n_chk++;   // R12 reset state
    if (rsp_valid !== 1'b0 || req_ready !== 1'b1) begin
      n_bad++;
      $display("FAIL R12 reset: got valid=%b ready=%b exp valid=0 ready=1", rsp_valid, req_ready);
    end
    @(negedge clk);
    rst_n = 1'b1;

    send(VA, 2'd0, 1'b0, 3'd4, OK, "R7 read sets accessed");
    send(VA, 2'd0, 1'b0, 3'd4, OK | 64'h20, "R8 read no change no strobe");
    send(VA, 2'd1, 1'b0, 3'd4, OK | 64'h20, "R7 write sets dirty");
    send(VA, 2'd1, 1'b1, 3'd4, OK | 64'h60, "R8 write already dirty");
    send(VA, 2'd2, 1'b0, 3'd4, OK, "R5 fetch allowed");
    send(VA, 2'd3, 1'b0, 3'd4, OK, "R5 reserved kind as read");
    send(VA, 2'd1, 1'b1, 3'd4, 64'hFFFF_FFFF_FFFF_FFFE, "R1 absent write");
    send(VA, 2'd2, 1'b0, 3'd7, FR, "R1 absent fetch");
    send(VA, 2'd0, 1'b0, 3'd3, OK | 64'h80, "R9 2MiB address");
    send(VA, 2'd0, 1'b0, 3'd2, OK | 64'h80, "R9 1GiB address");
    send(VA, 2'd0, 1'b0, 3'd4, OK | 64'h80, "R2 level4 ignores large bit");
    send(VA, 2'd0, 1'b0, 3'd3, OK, "R2 level3 without large bit");
    send(VA, 2'd0, 1'b0, 3'd1, OK | 64'h80, "R2 level1 invalid");
    send(VA, 2'd0, 1'b1, 3'd4, OK & ~64'h4, "R3 user denied");
    send(VA, 2'd0, 1'b0, 3'd4, OK & ~64'h4, "R3 supervisor allowed");
    send(VA, 2'd1, 1'b0, 3'd4, OK & ~64'h2, "R4 write protected");
    send(VA, 2'd0, 1'b0, 3'd4, OK & ~64'h2, "R4 read of readonly");
    send(VA, 2'd2, 1'b0, 3'd4, OK | (64'h1 << 63), "R5 no-execute fetch");
    send(VA, 2'd0, 1'b0, 3'd4, OK | (64'h1 << 63), "R5 read of no-exec page");
    send(VA, 2'd1, 1'b1, 3'd3, FR | (64'h1 << 63), "R6 absent beats all");
    send(VA, 2'd1, 1'b1, 3'd3, FR | 64'h1, "R6 shape beats privilege");
    send(VA, 2'd1, 1'b1, 3'd4, FR | 64'h1, "R6 privilege beats write");
    send(VA, 2'd1, 1'b0, 3'd4, FR | 64'h5, "R6 write beats others");
    send(VA, 2'd0, 1'b0, 3'd4, OK | 64'h8, "R10 write-through passed");

    repeat (4) @(posedge clk);
    stall_mode = 1'b1;
    lf = 32'hACE1_2345;
    for (int i = 0; i < 60; i++) begin
      logic [63:0] p;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      p = {lf[31], 11'd0, lf[19:0], lf, 32'd0} | {56'd0, lf[7:0] | 8'h01};
      send({lf[15:0], lf}, lf[9:8], lf[10], 3'd2 + 3'(lf[12:11] % 3), p, "R11 stalled stream R6");
    end
    stall_mode = 1'b0;
    repeat (20) @(posedge clk);
    n_chk++;
    if (expq.size() != 0) begin
      n_bad++;
      $display("FAIL R11 missing results: got %0d left exp 0", expq.size());
    end
    finish_run();
  end

endmodule